// File: doc/BRIEF.md
# Paged Register Map with Auto-Increment

This block is the byte-addressed register space that sits behind a serial-bus slave. A bus front end (not part of this block) marks the start of a transfer and supplies a start address. It then hands over one byte-level request per data byte. Each request either writes a byte or asks for one. An internal address counter selects the location and steps by one after every accepted byte. After the top location the counter rolls over to zero, so a long burst wraps around the map with no end.

The 256-byte space is split in two halves:

- **Lower half (00h–7Fh):** a fixed bank of control, status and measurement bytes. It is always visible.
- **Upper half (80h–FFh):** a window onto one of four 128-byte profile tables, one per output channel. The choice of table comes from the low nibble of the lower-bank byte at 7Fh, which is also driven out on `table_sel`. A table number with nothing behind it leaves the window empty.

**Request channel.** Requests use valid/ready. A beat is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while `start` is high. It is also low while a read response is waiting and `rsp_ready` is low.

**Response channel.** Read data comes back on a valid/ready response channel, one cycle after the read beat. It holds steady until the cycle in which `rsp_ready` is high. Write beats produce no response.

Top module: `paged_regmap`

## Requirements
- R1: After reset, `rsp_valid` is 0, `table_sel` is 0, and every location reads back 00h.
- R2: While `start` is high, `req_ready` is 0, and the address counter is loaded from `start_addr`. The next accepted beat uses that address.
- R3: Each accepted beat advances the counter by one. The counter holds while no beat is accepted. After FFh it goes to 00h, and reads continue across the wrap without limit.
- R4: Addresses 00h–7Fh always reach the same lower-bank byte, whatever `table_sel` holds.
- R5: When `table_sel` is 4, 5, 6 or 7, addresses 80h–FFh reach byte (address − 80h) of the table for channel 0, 1, 2 or 3 respectively. The four tables are independent.
- R6: When `table_sel` is any value other than 4–7, reads of 80h–FFh return 00h and writes there change no table.
- R7: `table_sel` equals bits [3:0] of the lower-bank byte at 7Fh. All 8 bits of that byte read back as written. A new selection applies from the very next beat, including the beat that follows the write at 7Fh when the counter moves on to 80h.
- R8: A read beat makes `rsp_valid` high on the next cycle, carrying the addressed byte. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` is held and `req_ready` is 0.
- R9: A write beat updates the addressed location and raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start of transfer: loads the address counter |
| start_addr | input | 8 | Address loaded while `start` is high |
| req_valid | input | 1 | Byte request valid |
| req_ready | output | 1 | Byte request accepted this edge when high with `req_valid` |
| req_write | input | 1 | 1 = write beat, 0 = read beat |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8 | Read response data |
| table_sel | output | 4 | Current table selection (low nibble of byte 7Fh) |

## Verification
On every cycle, the assertions check the following:

- The counter loads on `start`, steps by exactly one (modulo 256) on each accepted beat, and holds otherwise.
- A read beat always yields a response and a write beat never does.
- A stalled response keeps its data and blocks new requests.
- `table_sel` moves only just after a write beat at 7Fh.

Only the bench's scenarios can show the data paths, by comparing against its own model of the map:

- the lower bank staying fixed under every selection;
- the four tables being separate;
- the empty window for unused selections;
- the selection taking effect at the 7Fh-to-80h step;
- bursts that wrap past FFh.

// File: rtl/paged_regmap_pkg.sv
package paged_regmap_pkg;

  // Where the current beat lands in the map
  typedef enum logic [1:0] {
    REG_LOWER = 2'd0,
    REG_TABLE = 2'd1,
    REG_VOID  = 2'd2
  } region_e;

endpackage

// File: rtl/paged_regmap_addr_ctr.sv
module paged_regmap_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  // Natural modulo-2^ADDR_W rollover gives the FFh -> 00h wrap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/paged_regmap_lower_bank.sv
module paged_regmap_lower_bank #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 7,
  parameter int TSEL_W    = 4,
  parameter int TSEL_ADDR = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [TSEL_W-1:0] tsel
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
  assign tsel  = mem[TSEL_ADDR][TSEL_W-1:0];

endmodule

// File: rtl/paged_regmap_table_bank.sv
module paged_regmap_table_bank #(
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  parameter int NUM_TABLES = 4,
  parameter int TIDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TIDX_W-1:0] tidx,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] rd_arr [NUM_TABLES];

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tab
    logic [DATA_W-1:0] tmem [DEPTH];
    logic              tab_we;

    assign tab_we = we && (int'(tidx) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) tmem[i] <= '0;
      end else if (tab_we) begin
        tmem[idx] <= wdata;
      end
    end

    assign rd_arr[g] = tmem[idx];
  end

  always_comb begin
    rdata = '0;
    for (int t = 0; t < NUM_TABLES; t++) begin
      if (int'(tidx) == t) rdata = rd_arr[t];
    end
  end

endmodule

// File: rtl/paged_regmap.sv
module paged_regmap
  import paged_regmap_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int TSEL_W      = 4,
  parameter int NUM_TABLES  = 4,
  parameter int FIRST_TABLE = 4,
  parameter int TSEL_ADDR   = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [TSEL_W-1:0] table_sel
);

  localparam int IDX_W  = ADDR_W - 1;
  localparam int TIDX_W = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1;

  logic              fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  idx;
  region_e           region;
  logic              tsel_hit;
  logic [TIDX_W-1:0] tidx;
  logic [DATA_W-1:0] lo_rd;
  logic [DATA_W-1:0] tb_rd;
  logic [DATA_W-1:0] rd_mux;

  // Request handshake: blocked during start and while a response is stalled
  assign req_ready = !start && !(rsp_valid && !rsp_ready);
  assign fire      = req_valid && req_ready;

  paged_regmap_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (start_addr),
    .step     (fire),
    .addr     (cur_addr)
  );

  assign idx      = cur_addr[IDX_W-1:0];
  assign tsel_hit = (int'(table_sel) >= FIRST_TABLE) &&
                    (int'(table_sel) <  FIRST_TABLE + NUM_TABLES);
  assign tidx     = TIDX_W'(int'(table_sel) - FIRST_TABLE);

  always_comb begin
    if (!cur_addr[ADDR_W-1]) region = REG_LOWER;
    else if (tsel_hit)       region = REG_TABLE;
    else                     region = REG_VOID;
  end

  paged_regmap_lower_bank #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .TSEL_W    (TSEL_W),
    .TSEL_ADDR (TSEL_ADDR)
  ) u_lower (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fire && req_write && (region == REG_LOWER)),
    .idx   (idx),
    .wdata (req_wdata),
    .rdata (lo_rd),
    .tsel  (table_sel)
  );

  paged_regmap_table_bank #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .NUM_TABLES (NUM_TABLES),
    .TIDX_W     (TIDX_W)
  ) u_tables (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fire && req_write && (region == REG_TABLE)),
    .tidx  (tidx),
    .idx   (idx),
    .wdata (req_wdata),
    .rdata (tb_rd)
  );

  always_comb begin
    unique case (region)
      REG_LOWER: rd_mux = lo_rd;
      REG_TABLE: rd_mux = tb_rd;
      default:   rd_mux = '0;
    endcase
  end

  // Response register: loaded by a read beat, cleared once consumed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/paged_regmap_chk.sv
module paged_regmap_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int TSEL_W    = 4,
  parameter int TSEL_ADDR = 127
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [TSEL_W-1:0] table_sel,
  input logic [ADDR_W-1:0] cur_addr
);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_addr == $past(start_addr));

  p_start_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req_ready);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(req_valid && req_ready)) |=> $stable(cur_addr));

  p_tsel_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(table_sel) |-> $past(req_valid && req_ready && req_write &&
                                  (int'(cur_addr) == TSEL_ADDR)));

  p_read_responds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

endmodule

bind paged_regmap paged_regmap_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .TSEL_W    (TSEL_W),
  .TSEL_ADDR (TSEL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .table_sel  (table_sel),
  .cur_addr   (cur_addr)
);

// File: tb/paged_regmap_bench.sv
module paged_regmap_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_addr = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic [3:0] table_sel;

  always #10 clk = ~clk;  // 50 MHz

  paged_regmap u_paged_regmap (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .table_sel  (table_sel)
  );

  int    total = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int lower_m [128];
  int tab_m [4][128];
  int cnt_m;
  bit exp_v;
  int exp_d;

  function automatic int model_read(int a);
    int ts;
    if (a < 128) return lower_m[a];
    ts = lower_m[127] & 15;
    if (ts >= 4 && ts <= 7) return tab_m[ts-4][a-128];
    return 0;
  endfunction

  function automatic bit model_ready();
    return !start && !(exp_v && !rsp_ready);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (lower_m[i]) lower_m[i] = 0;
      foreach (tab_m[t, i]) tab_m[t][i] = 0;
      cnt_m = 0;
      exp_v = 0;
      exp_d = 0;
    end else begin
      bit f;
      int ts;
      f = req_valid && model_ready();
      if (f && !req_write) begin
        exp_v = 1;
        exp_d = model_read(cnt_m);
      end else if (exp_v && rsp_ready) begin
        exp_v = 0;
      end
      if (start) begin
        cnt_m = int'(start_addr);
      end else if (f) begin
        if (req_write) begin
          if (cnt_m < 128) begin
            lower_m[cnt_m] = int'(req_wdata);
          end else begin
            ts = lower_m[127] & 15;
            if (ts >= 4 && ts <= 7) tab_m[ts-4][cnt_m-128] = int'(req_wdata);
          end
        end
        cnt_m = (cnt_m + 1) % 256;
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, mid low phase
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      chk("R8", int'(req_ready), int'(model_ready()), "req_ready");
      chk("R8", int'(rsp_valid), int'(exp_v), "rsp_valid");
      if (exp_v && rsp_valid) chk(cur_req, int'(rsp_rdata), exp_d, "rsp_rdata");
      chk("R7", int'(table_sel), lower_m[127] & 15, "table_sel");
    end
  end

  // Optional back-pressure on the response channel
  bit       bp_en = 0;
  bit [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    if (bp_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[2];
    end else begin
      rsp_ready = 1'b1;
    end
  end

  task automatic do_start(int a);
    @(negedge clk);
    start = 1'b1;
    start_addr = 8'(a);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat(bit wr, int d);
    bit taken;
    req_valid = 1'b1;
    req_write = wr;
    req_wdata = 8'(d);
    taken = 0;
    while (!taken) begin
      #5;
      taken = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic rd_seq(int n);
    for (int i = 0; i < n; i++) beat(1'b0, 0);
  endtask

  task automatic wr_seq(int n, int base, int stp);
    for (int i = 0; i < n; i++) beat(1'b1, (base + i * stp) & 255);
  endtask

  task automatic set_tsel(int v);
    do_start(127);
    beat(1'b1, v);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
    chk("R1", int'(table_sel), 0, "table_sel after reset");

    // R1: whole map reads zero
    cur_req = "R1";
    do_start(0);
    rd_seq(256);

    // R4: fill lower bank, read back
    cur_req = "R4";
    do_start(0);
    wr_seq(127, 8'h11, 3);
    do_start(0);
    rd_seq(127);

    // R7: upper nibble kept, low nibble selects
    cur_req = "R7";
    set_tsel(8'hA4);
    do_start(127);
    rd_seq(1);

    // R5: fill each of the four tables with its own pattern
    cur_req = "R5";
    for (int t = 4; t < 8; t++) begin
      set_tsel(t);
      do_start(128);
      wr_seq(128, t * 37, t);
    end
    for (int t = 4; t < 8; t++) begin
      set_tsel(8'h30 | t);
      do_start(128);
      rd_seq(128);
    end
    cur_req = "R4";
    do_start(0);
    rd_seq(127);

    // R6: unused selections give an empty window
    cur_req = "R6";
    set_tsel(9);
    do_start(128);
    wr_seq(32, 8'hEE, 1);
    do_start(128);
    rd_seq(32);
    set_tsel(0);
    do_start(200);
    wr_seq(8, 8'h55, 0);
    rd_seq(8);
    set_tsel(15);
    do_start(240);
    rd_seq(4);
    set_tsel(4);
    do_start(128);
    rd_seq(40);

    // R7: selection applies on the beat right after 7Fh
    cur_req = "R7";
    do_start(126);
    beat(1'b1, 8'h77);
    beat(1'b1, 8'h06);
    beat(1'b1, 8'hC3);
    beat(1'b1, 8'hC4);
    do_start(126);
    rd_seq(4);
    set_tsel(5);
    do_start(128);
    rd_seq(2);

    // R3: wrap past FFh, writes and reads continue
    cur_req = "R3";
    set_tsel(7);
    do_start(250);
    wr_seq(12, 8'h90, 1);
    do_start(248);
    rd_seq(600);

    // R2: restart mid-burst at a new address
    cur_req = "R2";
    do_start(16);
    rd_seq(3);
    do_start(200);
    rd_seq(3);
    do_start(5);
    beat(1'b1, 8'h3C);
    do_start(5);
    rd_seq(1);

    // R8 / R9: back-pressure with mixed reads and writes
    cur_req = "R8";
    bp_en = 1;
    do_start(100);
    for (int i = 0; i < 200; i++) begin
      beat(i % 5 == 0, i);
      if (i % 7 == 0) @(negedge clk);
    end
    cur_req = "R9";
    do_start(120);
    wr_seq(20, 8'h42, 5);
    do_start(120);
    rd_seq(20);
    bp_en = 0;
    repeat (6) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule